// File: doc/BRIEF.md
# Vector Condition-Code Write Gate

This block holds a four-component condition register. Each component keeps three mutually exclusive flags: below zero, at zero and above zero. An instruction that asks for an update refreshes all four components from per-component sign and zero indications of its result. The block never sees the result values themselves, only those indications.

On every instruction the block reads a 3-bit relational code and a swizzle of the condition register, and uses them to gate the instruction's 4-bit destination write mask one component at a time. It also returns a scalar pass flag for branches, taken from the swizzled X component. Gating is applied only when the instruction asks for a test. An update lands at the clock edge that closes the instruction, so the instruction's own test always sees the flags as they stood before it.

Top module: `vcc_gate`

## Requirements
- R1: When `valid_i` and `update_en_i` are both high at a rising clock edge, each component k is loaded with flags {gt,eq,lt} (lt = bit0, eq = bit1, gt = bit2). The value is 3'b010 when `res_zero_i[k]` is set, whatever `res_neg_i[k]` holds. Otherwise it is 3'b001 when `res_neg_i[k]` is set, and 3'b100 when neither is set.
- R2: After reset, all four components hold the at-zero flag (3'b010).
- R3: With `test_en_i` low, `wen_o` equals `wmask_i` and `branch_pass_o` is 1.
- R4: The code is a flag set with lt = bit0, eq = bit1 and gt = bit2. Code 0 never passes and code 7 always passes. In general, a component passes when the bitwise AND of the code and the component's swizzled flags is non-zero.
- R5: `cond_swz_i` holds one 2-bit selector per tested component, with X in bits [7:6], Y in [5:4], Z in [3:2] and W in [1:0]. The selector value 0..3 picks stored component X..W.
- R6: With `test_en_i` high, `wen_o[k]` is `wmask_i[k]` AND the pass result of tested component k.
- R7: With `test_en_i` high, `branch_pass_o` is the pass result of the swizzled X component.
- R8: An update does not affect the outputs of the instruction that carries it. The new flags are seen from the next cycle on.
- R9: The condition register keeps its value on any edge where `valid_i` or `update_en_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Instruction present this cycle |
| cond_code_i | input | 3 | Relational code (lt/eq/gt flag set) |
| cond_swz_i | input | 8 | Condition register swizzle, X selector in MSBs |
| test_en_i | input | 1 | Gate the write mask by the condition |
| update_en_i | input | 1 | Refresh the condition register from the result |
| wmask_i | input | 4 | Destination write mask, bit 0 = X |
| res_neg_i | input | 4 | Per-component result is negative |
| res_zero_i | input | 4 | Per-component result is zero |
| wen_o | output | 4 | Effective per-component write enables |
| branch_pass_o | output | 1 | Scalar condition for a branch |

## Verification
The condition register can only be seen through the gating it applies. A wrong stored flag therefore appears as a wrong `wen_o` bit or a wrong `branch_pass_o`, starting on the first tested instruction after the faulty edge, and only when that instruction has a code and swizzle that look at the affected component and flag. For this reason the bench loads every one of the 81 flag combinations and sweeps all codes and swizzles against each. A timing slip, where the update becomes visible in its own instruction, shows up in the same cycle as the update.

// File: rtl/vcc_pkg.sv
package vcc_pkg;
  localparam int unsigned FLAG_W = 3;
  typedef logic [FLAG_W-1:0] flags_t;

  localparam flags_t FLAG_LT = 3'b001;
  localparam flags_t FLAG_EQ = 3'b010;
  localparam flags_t FLAG_GT = 3'b100;

  typedef enum logic [2:0] {
    CC_FL = 3'd0, CC_LT = 3'd1, CC_EQ = 3'd2, CC_LE = 3'd3,
    CC_GT = 3'd4, CC_NE = 3'd5, CC_GE = 3'd6, CC_TR = 3'd7
  } cc_code_e;
endpackage

// File: rtl/vcc_flag_encode.sv
module vcc_flag_encode
  import vcc_pkg::*;
#(
  parameter int unsigned NUM_COMP = 4
) (
  input  logic [NUM_COMP-1:0]              neg_i,
  input  logic [NUM_COMP-1:0]              zero_i,
  output logic [NUM_COMP-1:0][FLAG_W-1:0]  flags_o
);
  for (genvar k = 0; k < NUM_COMP; k++) begin : g_comp
    // zero dominates sign
    always_comb begin
      if (zero_i[k])     flags_o[k] = FLAG_EQ;
      else if (neg_i[k]) flags_o[k] = FLAG_LT;
      else               flags_o[k] = FLAG_GT;
    end
  end
endmodule

// File: rtl/vcc_flag_reg.sv
module vcc_flag_reg
  import vcc_pkg::*;
#(
  parameter int unsigned NUM_COMP = 4
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             load_i,
  input  logic [NUM_COMP-1:0][FLAG_W-1:0]  flags_d_i,
  output logic [NUM_COMP-1:0][FLAG_W-1:0]  flags_q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flags_q_o <= {NUM_COMP{FLAG_EQ}};
    else if (load_i) flags_q_o <= flags_d_i;
  end

  for (genvar k = 0; k < NUM_COMP; k++) begin : g_chk
    a_r1_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot(flags_q_o[k]));
  end

  a_r9_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(flags_q_o));
endmodule

// File: rtl/vcc_swizzle.sv
module vcc_swizzle
  import vcc_pkg::*;
#(
  parameter int unsigned NUM_COMP = 4,
  localparam int unsigned SEL_W   = $clog2(NUM_COMP),
  localparam int unsigned SWZ_W   = NUM_COMP * SEL_W
) (
  input  logic [NUM_COMP-1:0][FLAG_W-1:0]  flags_i,
  input  logic [SWZ_W-1:0]                 swz_i,
  output logic [NUM_COMP-1:0][FLAG_W-1:0]  flags_o
);
  // component 0 (X) takes the most significant selector
  for (genvar k = 0; k < NUM_COMP; k++) begin : g_sel
    logic [SEL_W-1:0] sel;
    assign sel        = swz_i[SWZ_W-1-k*SEL_W -: SEL_W];
    assign flags_o[k] = flags_i[sel];
  end
endmodule

// File: rtl/vcc_relate.sv
module vcc_relate
  import vcc_pkg::*;
#(
  parameter int unsigned NUM_COMP = 4
) (
  input  logic [FLAG_W-1:0]                code_i,
  input  logic [NUM_COMP-1:0][FLAG_W-1:0]  flags_i,
  output logic [NUM_COMP-1:0]              pass_o
);
  for (genvar k = 0; k < NUM_COMP; k++) begin : g_rel
    assign pass_o[k] = |(code_i & flags_i[k]);
  end
endmodule

// File: rtl/vcc_gate.sv
module vcc_gate
  import vcc_pkg::*;
#(
  parameter int unsigned NUM_COMP = 4,
  localparam int unsigned SEL_W   = $clog2(NUM_COMP),
  localparam int unsigned SWZ_W   = NUM_COMP * SEL_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 valid_i,
  input  logic [2:0]           cond_code_i,
  input  logic [SWZ_W-1:0]     cond_swz_i,
  input  logic                 test_en_i,
  input  logic                 update_en_i,
  input  logic [NUM_COMP-1:0]  wmask_i,
  input  logic [NUM_COMP-1:0]  res_neg_i,
  input  logic [NUM_COMP-1:0]  res_zero_i,
  output logic [NUM_COMP-1:0]  wen_o,
  output logic                 branch_pass_o
);
  logic [NUM_COMP-1:0][FLAG_W-1:0] flags_d, flags_q, flags_swz;
  logic [NUM_COMP-1:0]             pass;
  logic                            load;
  cc_code_e                        code;

  assign code = cc_code_e'(cond_code_i);
  assign load = valid_i & update_en_i;

  vcc_flag_encode #(.NUM_COMP(NUM_COMP)) u_enc (
    .neg_i(res_neg_i), .zero_i(res_zero_i), .flags_o(flags_d));

  vcc_flag_reg #(.NUM_COMP(NUM_COMP)) u_reg (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load),
    .flags_d_i(flags_d), .flags_q_o(flags_q));

  vcc_swizzle #(.NUM_COMP(NUM_COMP)) u_swz (
    .flags_i(flags_q), .swz_i(cond_swz_i), .flags_o(flags_swz));

  vcc_relate #(.NUM_COMP(NUM_COMP)) u_rel (
    .code_i(code), .flags_i(flags_swz), .pass_o(pass));

  // tests read the registered flags, so an update is seen one cycle later
  assign wen_o         = test_en_i ? (wmask_i & pass) : wmask_i;
  assign branch_pass_o = test_en_i ? pass[0] : 1'b1;

  a_r3_passthru: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !test_en_i |-> (wen_o == wmask_i) && branch_pass_o);

  a_r6_subset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wen_o & ~wmask_i) == '0);

  a_r4_never: assert property (@(posedge clk_i) disable iff (!rst_ni)
    test_en_i && (code == CC_FL) |-> (wen_o == '0) && !branch_pass_o);

  a_r4_always: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code == CC_TR) |-> (wen_o == wmask_i) && branch_pass_o);

  a_r1_zero_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load && res_zero_i[0] |=> flags_q[0] == FLAG_EQ);

  a_r1_neg_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load && res_neg_i[0] && !res_zero_i[0] |=> flags_q[0] == FLAG_LT);
endmodule

// File: tb/vcc_gate_bench.sv
module vcc_gate_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       valid = 1'b0, test_en = 1'b0, upd = 1'b0;
  logic [2:0] code = '0;
  logic [7:0] swz = '0;
  logic [3:0] mask = '0, neg = '0, zero = '0;
  logic [3:0] wen;
  logic       bpass;

  int checks = 0, errors = 0;
  logic [2:0] mflags [4];

  always #4 clk = ~clk;

  vcc_gate u_vcc_gate (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .cond_code_i(code),
    .cond_swz_i(swz), .test_en_i(test_en), .update_en_i(upd), .wmask_i(mask),
    .res_neg_i(neg), .res_zero_i(zero), .wen_o(wen), .branch_pass_o(bpass));

  function automatic logic [2:0] enc(input logic n, input logic z);
    if (z) return 3'b010;
    if (n) return 3'b001;
    return 3'b100;
  endfunction

  // R4/R5/R6/R7 reference: drive inputs, settle, compare
  task automatic chk(input logic [2:0] c, input logic [7:0] s, input logic [3:0] m,
                     input logic t, input string tag);
    logic [3:0] p, we;
    logic       be;
    code = c; swz = s; mask = m; test_en = t;
    #1;
    for (int k = 0; k < 4; k++) p[k] = |(c & mflags[s[7-2*k -: 2]]);
    we = t ? (m & p) : m;
    be = t ? p[0] : 1'b1;
    checks++;
    if (wen !== we || bpass !== be) begin
      errors++;
      $display("FAIL %s code=%0d swz=%h mask=%h: wen=%b bpass=%b expected wen=%b bpass=%b",
               tag, c, s, m, wen, bpass, we, be);
    end
  endtask

  task automatic load(input logic [3:0] n, input logic [3:0] z);
    @(negedge clk);
    valid = 1'b1; upd = 1'b1; neg = n; zero = z; test_en = 1'b0;
    @(posedge clk);
    for (int k = 0; k < 4; k++) mflags[k] = enc(n[k], z[k]);
    @(negedge clk);
    valid = 1'b0; upd = 1'b0;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    for (int k = 0; k < 4; k++) mflags[k] = 3'b010;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    // R2: reset state is at-zero everywhere
    chk(3'd2, 8'h1B, 4'hF, 1'b1, "R2");
    chk(3'd5, 8'h1B, 4'hF, 1'b1, "R2");
    // R3: test disabled passes mask through
    chk(3'd0, 8'h1B, 4'hA, 1'b0, "R3");

    // R8: update in same cycle uses old flags
    @(negedge clk);
    valid = 1'b1; upd = 1'b1; neg = 4'h0; zero = 4'h0;
    chk(3'd2, 8'h1B, 4'hF, 1'b1, "R8");
    @(posedge clk);
    for (int k = 0; k < 4; k++) mflags[k] = 3'b100;
    @(negedge clk);
    valid = 1'b0; upd = 1'b0;
    chk(3'd2, 8'h1B, 4'hF, 1'b1, "R8");
    chk(3'd4, 8'h1B, 4'hF, 1'b1, "R8");

    // R9: no load with update low or valid low
    @(negedge clk);
    valid = 1'b1; upd = 1'b0; neg = 4'hF; zero = 4'h0;
    @(negedge clk);
    valid = 1'b0; upd = 1'b1;
    @(negedge clk);
    upd = 1'b0;
    chk(3'd4, 8'h1B, 4'hF, 1'b1, "R9");
    chk(3'd1, 8'h1B, 4'hF, 1'b1, "R9");

    // R1: zero dominates sign
    load(4'hF, 4'h5);
    chk(3'd2, 8'h1B, 4'hF, 1'b1, "R1");
    chk(3'd1, 8'h1B, 4'hF, 1'b1, "R1");

    // R1/R4/R5/R6/R7: every stored pattern, every code and swizzle
    for (int st = 0; st < 81; st++) begin
      logic [3:0] n, z;
      int v;
      v = st;
      for (int k = 0; k < 4; k++) begin
        n[k] = (v % 3) == 0;
        z[k] = (v % 3) == 1;
        v = v / 3;
      end
      load(n, z);
      for (int c = 0; c < 8; c++)
        for (int s = 0; s < 256; s++) begin
          logic [7:0] s8;
          s8 = 8'(s);
          chk(3'(c), s8, s8[3:0] ^ 4'(st), 1'b1,
              (c == 0 || c == 7) ? "R4" : "R6");
          if (s8[3:0] == 4'h0) chk(3'(c), s8, 4'(st), 1'b0, "R3");
        end
    end
    finish_run();
  end
endmodule